// File: doc/BRIEF.md
# Multi-format serial line encoder

This block turns a serial stream of data bits into one of four line codes: plain level coding (NRZ), transition-on-one coding (NRZI), return-to-zero (RZ) and Manchester. It runs on one clock at twice the bit rate, so each data bit occupies two clock cycles, the early half and the late half. A strobe input marks the early half of every bit. In that cycle the block captures the data bit and the format select and holds both for the rest of the bit.

Two copies of the encoded line are driven. The Mealy line is formed in the same cycle from the current inputs and the held state, so the early half of a bit appears in the cycle its strobe is high. The Moore line is the Mealy line passed through one register. It is glitch-free and trails the Mealy line by one clock cycle, which is half a bit period. A system uses one or the other depending on its timing budget.

Top module: `line_encoder`

## Requirements
- R1: While rst_n is low, and after its release until the first strobe, both line outputs are 0. Reset clears the held bit to 0, the held format to NRZ and the NRZI level to 0.
- R2: din and fmt_sel are used only in a cycle with bit_stb high. Changing them in a late-half cycle does not change that cycle's line.
- R3: Format code 2'b00 (NRZ) drives the data bit on the line in both halves of the bit.
- R4: Format code 2'b01 (NRZI) drives the stored level XOR the bit in the early half and keeps that level in the late half. The stored level toggles on a 1 and holds on a 0.
- R5: Format code 2'b10 (RZ) drives the bit in the early half and 0 in the late half.
- R6: Format code 2'b11 (Manchester) drives the bit in the early half and its complement in the late half.
- R7: A new fmt_sel value takes effect only from the next cycle with bit_stb high.
- R8: enc_moore equals the value enc_mealy had one clock cycle earlier.
- R9: The NRZI level is unchanged across bits sent in any other format, and it resumes from that level when NRZI is selected again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_stb | input | 1 | High in the early-half cycle of each bit |
| din | input | 1 | Serial data bit, valid when bit_stb is high |
| fmt_sel | input | 2 | Line code select: 00 NRZ, 01 NRZI, 10 RZ, 11 Manchester |
| enc_mealy | output | 1 | Encoded line, combinational from inputs and state |
| enc_moore | output | 1 | Encoded line, registered, one cycle behind enc_mealy |

## Verification
A format change and a data capture can land on the same strobe edge. Whether NRZI then toggles depends on the incoming format rather than the outgoing one. The bench provokes this by drawing a new random format together with each new bit, and by directed switches into and out of NRZI. For every cycle, a model in the bench computes the expected level from the format in force and compares it with both lines. The late-half inputs are also randomised, and they must have no effect on the line.

// File: rtl/lenc_pkg.sv
package lenc_pkg;
  localparam int FMT_W = 2;

  typedef enum logic [FMT_W-1:0] {
    FMT_NRZ  = 2'b00,
    FMT_NRZI = 2'b01,
    FMT_RZ   = 2'b10,
    FMT_MAN  = 2'b11
  } line_fmt_e;
endpackage

// File: rtl/lenc_hold.sv
module lenc_hold
  import lenc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_stb,
  input  logic      din,
  input  line_fmt_e fmt_in,
  output logic      bit_q,
  output line_fmt_e fmt_q,
  output logic      lvl_q
);
  logic      bit_d;
  line_fmt_e fmt_d;
  logic      lvl_d;

  // next-state: capture only on the early-half strobe
  always_comb begin
    bit_d = bit_q;
    fmt_d = fmt_q;
    lvl_d = lvl_q;
    if (bit_stb) begin
      bit_d = din;
      fmt_d = fmt_in;
      if (fmt_in == FMT_NRZI) begin
        lvl_d = lvl_q ^ din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      fmt_q <= FMT_NRZ;
      lvl_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
      fmt_q <= fmt_d;
      lvl_q <= lvl_d;
    end
  end

  AST_NRZI_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && fmt_in == FMT_NRZI && !din) |=> $stable(lvl_q)); // R4
  AST_NRZI_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && fmt_in == FMT_NRZI && din) |=> (lvl_q != $past(lvl_q))); // R4
  AST_LVL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb || fmt_in != FMT_NRZI) |=> $stable(lvl_q)); // R9
  AST_LATE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> ($stable(bit_q) && $stable(fmt_q))); // R2
endmodule

// File: rtl/lenc_shape.sv
module lenc_shape
  import lenc_pkg::*;
(
  input  logic      bit_stb,
  input  logic      din,
  input  line_fmt_e fmt_in,
  input  logic      bit_q,
  input  line_fmt_e fmt_q,
  input  logic      lvl_q,
  output logic      line_o
);
  logic early_v;
  logic late_v;

  // early half: new bit and new format straight from the inputs
  always_comb begin
    unique case (fmt_in)
      FMT_NRZI: early_v = lvl_q ^ din;
      default:  early_v = din;
    endcase
  end

  // late half: held bit and held format
  always_comb begin
    unique case (fmt_q)
      FMT_NRZ:  late_v = bit_q;
      FMT_NRZI: late_v = lvl_q;
      FMT_RZ:   late_v = 1'b0;
      FMT_MAN:  late_v = ~bit_q;
      default:  late_v = 1'b0;
    endcase
  end

  assign line_o = bit_stb ? early_v : late_v;
endmodule

// File: rtl/lenc_retime.sv
module lenc_retime (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic q_d;

  assign q_d = d_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_out <= 1'b0;
    end else begin
      q_out <= q_d;
    end
  end
endmodule

// File: rtl/line_encoder.sv
module line_encoder
  import lenc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb,
  input  logic                din,
  input  logic [FMT_W-1:0]    fmt_sel,
  output logic                enc_mealy,
  output logic                enc_moore
);
  line_fmt_e fmt_in;
  line_fmt_e fmt_q;
  logic      bit_q;
  logic      lvl_q;

  assign fmt_in = line_fmt_e'(fmt_sel);

  lenc_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_stb (bit_stb),
    .din     (din),
    .fmt_in  (fmt_in),
    .bit_q   (bit_q),
    .fmt_q   (fmt_q),
    .lvl_q   (lvl_q)
  );

  lenc_shape u_shape (
    .bit_stb (bit_stb),
    .din     (din),
    .fmt_in  (fmt_in),
    .bit_q   (bit_q),
    .fmt_q   (fmt_q),
    .lvl_q   (lvl_q),
    .line_o  (enc_mealy)
  );

  lenc_retime u_retime (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (enc_mealy),
    .q_out (enc_moore)
  );

  AST_MOORE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (enc_moore == $past(enc_mealy))); // R8
  AST_RZ_LATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && fmt_sel == FMT_RZ) |=> (!bit_stb -> !enc_mealy)); // R5
  AST_MAN_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && fmt_sel == FMT_MAN) |=> (!bit_stb -> (enc_mealy != $past(enc_mealy)))); // R6
  AST_NRZ_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && fmt_sel == FMT_NRZ) |=> (!bit_stb -> (enc_mealy == $past(din)))); // R3
endmodule

// File: tb/test_line_encoder.sv
module test_line_encoder;
  logic       clk;
  logic       rst_n;
  logic       bit_stb;
  logic       din;
  logic [1:0] fmt_sel;
  logic       enc_mealy;
  logic       enc_moore;

  int n_chk;
  int n_bad;

  // bench model state
  bit       m_bit;
  bit [1:0] m_fmt;
  bit       m_lvl;
  bit       m_prev;

  line_encoder i_line_encoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .din       (din),
    .fmt_sel   (fmt_sel),
    .enc_mealy (enc_mealy),
    .enc_moore (enc_moore)
  );

  initial clk = 1'b0;
  always #4ns clk = ~clk;

  function automatic bit exp_line(bit stb, bit d, bit [1:0] f);
    if (stb) begin
      if (f == 2'b01) return m_lvl ^ d;
      return d;
    end
    case (m_fmt)
      2'b00:   return m_bit;
      2'b01:   return m_lvl;
      2'b10:   return 1'b0;
      default: return ~m_bit;
    endcase
  endfunction

  function automatic string auto_tag(bit stb, bit [1:0] f);
    bit [1:0] k;
    k = stb ? f : m_fmt;
    case (k)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock cycle: drive at negedge, check, then advance model past posedge
  task automatic step(bit stb, bit d, bit [1:0] f, string tag);
    bit e;
    @(negedge clk);
    bit_stb = stb;
    din     = d;
    fmt_sel = f;
    #1ns;
    e = exp_line(stb, d, f);
    check((tag == "") ? auto_tag(stb, f) : tag, enc_mealy, e);
    check("R8", enc_moore, m_prev);
    m_prev = e;
    if (stb) begin
      m_bit = d;
      m_fmt = f;
      if (f == 2'b01) m_lvl = m_lvl ^ d;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    bit_stb = 1'b0;
    din     = 1'b1;
    fmt_sel = 2'b11;
    #1ns;
    check("R1", enc_mealy, 1'b0);
    check("R1", enc_moore, 1'b0);
    m_bit = 0; m_fmt = 0; m_lvl = 0; m_prev = 0;
    @(negedge clk);
    rst_n = 1'b1;
    #1ns;
    check("R1", enc_mealy, 1'b0);
    check("R1", enc_moore, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; bit_stb = 1'b0; din = 1'b0; fmt_sel = 2'b00;
    m_bit = 0; m_fmt = 0; m_lvl = 0; m_prev = 0;
    void'($urandom(32'd2024));
    do_reset();

    // R1: idle after release, no strobe yet
    step(0, 1, 2'b11, "R1");
    step(0, 1, 2'b10, "R1");

    // directed R3/R5/R6 per format with both bit values
    for (int f = 0; f < 4; f++) begin
      for (int b = 0; b < 2; b++) begin
        step(1, b[0], f[1:0], "");
        step(0, ~b[0], ~f[1:0], "");
      end
    end

    // R4: NRZI runs of ones and zeros
    step(1, 1, 2'b01, "R4"); step(0, 0, 2'b00, "R4");
    step(1, 1, 2'b01, "R4"); step(0, 1, 2'b10, "R4");
    step(1, 0, 2'b01, "R4"); step(0, 1, 2'b11, "R4");
    step(1, 1, 2'b01, "R4"); step(0, 0, 2'b01, "R4");

    // R9: leave NRZI, send ones elsewhere, come back
    step(1, 1, 2'b11, "R9"); step(0, 0, 2'b01, "R9");
    step(1, 1, 2'b00, "R9"); step(0, 0, 2'b01, "R9");
    step(1, 0, 2'b01, "R9"); step(0, 1, 2'b00, "R9");

    // R7 / R2: format and data change in the late half have no effect
    step(1, 1, 2'b10, "R7"); step(0, 1, 2'b00, "R7");
    step(1, 1, 2'b11, "R7"); step(0, 1, 2'b00, "R2");
    step(0, 0, 2'b01, "R2");

    // mid-run reset clears NRZI level and held format
    step(1, 1, 2'b01, "R4");
    do_reset();
    step(1, 0, 2'b01, "R1");
    step(0, 1, 2'b11, "R1");

    // random traffic, including strobe gaps
    for (int i = 0; i < 3000; i++) begin
      bit       d;
      bit [1:0] f;
      d = 1'($urandom);
      f = 2'($urandom);
      step(1, d, f, "");
      step(0, 1'($urandom), 2'($urandom), "");
      if (($urandom % 16) == 0) step(0, 1'($urandom), 2'($urandom), "R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule